// File: doc/BRIEF.md
# Parallel Bitstream Configuration Loader

This block acts as the host side of a byte-wide slave parallel configuration port. A pulse on `start`, together with a total byte count, begins a load. The loader pulses the program pin and waits for the target device to report readiness. It then holds chip-select and write asserted and moves one image byte per configuration clock cycle. The bytes arrive on a ready/valid stream. After the last byte it releases the port and keeps clocking until the device raises its done flag.

Every wait is bounded by a timeout counted in system-clock cycles. The timer restarts at the entry of each wait phase. A timeout ends the load with a one-cycle abort pulse and a status code that names the phase that hung. An optional busy stall makes the loader repeat clock cycles on the same data while the device reports busy.

All device-side pins here are active high: 1 means asserted. Device inputs are taken as already synchronous to `clk`.

Top module: `cfg_par_loader`

## Requirements
- R1: A `start` pulse in the idle state asserts `devProg` for exactly PROG_CYC system cycles and then releases it. `devSel` and `devWrite` stay low while `devProg` is high.
- R2: After `devProg` is released, the loader waits until `cfgInit` is 1 and `cfgBusy` is 0. If that does not happen within TIMEOUT_CYC cycles, status becomes 3 and `devSel` is never asserted.
- R3: On readiness, `devSel` and `devWrite` rise together while `devClk` is high, before any data clock.
- R4: For each byte, `devData` is updated at least one cycle before `devClk` falls and is held while it is low. `devClk` stays low for exactly HALF_CYC cycles and then rises. Bytes leave in stream order, one rising edge per byte.
- R5: `inReady` is 1 only while the loader waits for the next byte, with `devSel`, `devWrite` and `devClk` high. A byte is taken when `inValid` and `inReady` are both 1, and gaps in `inValid` lose no data.
- R6: After the last byte, `devSel` is released first and `devWrite` exactly one cycle later.
- R7: With `stallEn`=1, if `cfgBusy` is 1 at the end of a data clock's high phase, further clock cycles are issued on the same data until busy clears. With `stallEn`=0, `cfgBusy` during the data phase has no effect.
- R8: A busy stall lasting longer than TIMEOUT_CYC cycles ends the load with status 4.
- R9: After write is released, the loader issues clock cycles until `cfgDone` is seen high, with no extra clock once it is seen. It then reports status 2.
- R10: If `cfgDone` stays low for TIMEOUT_CYC cycles after write release, status becomes 5.
- R11: Every timeout raises `abortPulse` for exactly one cycle, and `devSel` and `devWrite` are low afterwards.
- R12: Status codes: 0 idle after reset, 1 running, 2 success, 3 ready timeout, 4 busy timeout, 5 done timeout. Status is 1 throughout a load and holds its final value until the next start.
- R13: `start` while a load is running is ignored.
- R14: A load with a byte count of zero issues no data clocks and goes straight to the done phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| byteTotal | input | CNT_W | Number of image bytes, sampled at start |
| stallEn | input | 1 | Enables the busy stall during the data phase |
| inData | input | 8 | Image byte from the stream |
| inValid | input | 1 | Stream byte present |
| inReady | output | 1 | Loader accepts a byte this cycle |
| cfgInit | input | 1 | Device ready flag (1 = cleared and ready) |
| cfgBusy | input | 1 | Device busy flag |
| cfgDone | input | 1 | Device configuration complete flag |
| devProg | output | 1 | Program pin, 1 = asserted |
| devSel | output | 1 | Chip-select, 1 = asserted |
| devWrite | output | 1 | Write enable, 1 = asserted |
| devClk | output | 1 | Configuration clock, parked high |
| devData | output | 8 | Configuration data bus |
| abortPulse | output | 1 | One-cycle pulse on any timeout |
| status | output | 3 | Load status code (see R12) |

## Verification
Properties check several things on every cycle. Data must be stable whenever the configuration clock falls. Program must exclude select and write. Write may not drop while select is held. Select must rise only with write and a high clock. The stream may be accepted only with the port open. The status must read running in every non-idle state. The abort pulse must last one cycle and carry a timeout code. The directed scenarios are needed for the counts and orderings that span a whole load: the byte sequence received by a device model, the stall clock count and the post-load clock count. They also cover each of the three timeouts and the effect of a start request in mid-load.

// File: rtl/cfg_par_loader_pkg.sv
package cfg_par_loader_pkg;

  typedef enum logic [2:0] {
    LD_IDLE    = 3'd0,
    LD_RUN     = 3'd1,
    LD_OK      = 3'd2,
    LD_RDY_TO  = 3'd3,
    LD_BSY_TO  = 3'd4,
    LD_DONE_TO = 3'd5
  } ld_status_e;

  // strobes from control to datapath, each effective at the next edge
  typedef struct packed {
    logic progOn;
    logic progOff;
    logic selOn;
    logic selOff;
    logic wrOn;
    logic wrOff;
    logic clkLow;
    logic clkHigh;
    logic loadByte;
    logic cntLoad;
    logic cntDec;
    logic dlyProg;
    logic dlyHalf;
    logic tmrClear;
  } dp_ctl_t;

endpackage

// File: rtl/cfg_par_datapath.sv
module cfg_par_datapath
  import cfg_par_loader_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 24,
  parameter int PROG_CYC    = 100,
  parameter int HALF_CYC    = 2,
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic [CNT_W-1:0]  byteTotal,
  output logic              devProg,
  output logic              devSel,
  output logic              devWrite,
  output logic              devClk,
  output logic [DATA_W-1:0] devData,
  output logic              dlyDone,
  output logic              tmrExpired,
  output logic              bytesLeftZero
);

  localparam int DLY_MAX = (PROG_CYC > HALF_CYC) ? PROG_CYC : HALF_CYC;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int TMR_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [DLY_W-1:0] PROG_LOAD = DLY_W'(PROG_CYC - 1);
  localparam logic [DLY_W-1:0] HALF_LOAD = DLY_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_LAST  = TMR_W'(TIMEOUT_CYC - 1);

  logic [DLY_W-1:0] dlyCnt;
  logic [TMR_W-1:0] tmrCnt;
  logic [CNT_W-1:0] bytesLeft;

  // device pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devProg  <= 1'b0;
      devSel   <= 1'b0;
      devWrite <= 1'b0;
      devClk   <= 1'b1;
      devData  <= '0;
    end else begin
      if (ctl.progOn)        devProg  <= 1'b1;
      else if (ctl.progOff)  devProg  <= 1'b0;
      if (ctl.selOn)         devSel   <= 1'b1;
      else if (ctl.selOff)   devSel   <= 1'b0;
      if (ctl.wrOn)          devWrite <= 1'b1;
      else if (ctl.wrOff)    devWrite <= 1'b0;
      if (ctl.clkLow)        devClk   <= 1'b0;
      else if (ctl.clkHigh)  devClk   <= 1'b1;
      if (ctl.loadByte)      devData  <= inData;
    end
  end

  // phase delay counter: program hold and clock half periods
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dlyCnt <= '0;
    else if (ctl.dlyProg)     dlyCnt <= PROG_LOAD;
    else if (ctl.dlyHalf)     dlyCnt <= HALF_LOAD;
    else if (dlyCnt != '0)    dlyCnt <= dlyCnt - 1'b1;
  end
  assign dlyDone = (dlyCnt == '0);

  // wait timer, restarted on entry of each wait phase, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tmrCnt <= '0;
    else if (ctl.tmrClear)      tmrCnt <= '0;
    else if (tmrCnt != TMR_LAST) tmrCnt <= tmrCnt + 1'b1;
  end
  assign tmrExpired = (tmrCnt == TMR_LAST);

  // remaining byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bytesLeft <= '0;
    else if (ctl.cntLoad)  bytesLeft <= byteTotal;
    else if (ctl.cntDec)   bytesLeft <= bytesLeft - 1'b1;
  end
  assign bytesLeftZero = (bytesLeft == '0);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devClk) |-> $stable(devData));

  // R4
  low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(devClk) && (HALF_CYC > 1)) |=> !devClk);

  // R1
  prog_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    devProg |-> (!devSel && !devWrite));

  // R6
  write_after_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devWrite) |-> !devSel);

endmodule

// File: rtl/cfg_par_control.sv
module cfg_par_control
  import cfg_par_loader_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       stallEn,
  input  logic       inValid,
  input  logic       cfgInit,
  input  logic       cfgBusy,
  input  logic       cfgDone,
  input  logic       dlyDone,
  input  logic       tmrExpired,
  input  logic       bytesLeftZero,
  output dp_ctl_t    ctl,
  output logic       inReady,
  output logic       abortPulse,
  output logic [2:0] status
);

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_RDY, S_FETCH, S_LOWGO, S_LOW, S_HIGH,
    S_DESEL, S_WROFF, S_DCHK
  } state_e;

  typedef enum logic [1:0] { P_BYTE, P_STALL, P_DONE } phase_e;

  state_e     state, stateNxt;
  phase_e     phase, phaseNxt;
  ld_status_e stat, statNxt;
  logic       abortNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    phaseNxt = phase;
    statNxt  = stat;
    abortNxt = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        ctl.progOn  = 1'b1;
        ctl.dlyProg = 1'b1;
        ctl.cntLoad = 1'b1;
        statNxt     = LD_RUN;
        stateNxt    = S_PROG;
      end
      S_PROG: if (dlyDone) begin
        ctl.progOff  = 1'b1;
        ctl.tmrClear = 1'b1;
        stateNxt     = S_RDY;
      end
      S_RDY: begin
        if (cfgInit && !cfgBusy) begin
          ctl.selOn   = 1'b1;
          ctl.wrOn    = 1'b1;
          ctl.clkHigh = 1'b1;
          phaseNxt    = P_BYTE;
          stateNxt    = bytesLeftZero ? S_DESEL : S_FETCH;
        end else if (tmrExpired) begin
          ctl.selOff = 1'b1;
          ctl.wrOff  = 1'b1;
          abortNxt   = 1'b1;
          statNxt    = LD_RDY_TO;
          stateNxt   = S_IDLE;
        end
      end
      S_FETCH: if (inValid) begin
        ctl.loadByte = 1'b1;
        ctl.cntDec   = 1'b1;
        stateNxt     = S_LOWGO;
      end
      S_LOWGO: begin
        ctl.clkLow  = 1'b1;
        ctl.dlyHalf = 1'b1;
        stateNxt    = S_LOW;
      end
      S_LOW: if (dlyDone) begin
        ctl.clkHigh = 1'b1;
        ctl.dlyHalf = 1'b1;
        stateNxt    = S_HIGH;
      end
      S_HIGH: if (dlyDone) begin
        if (phase == P_DONE) begin
          stateNxt = S_DCHK;
        end else if (stallEn && cfgBusy) begin
          if (phase == P_BYTE) begin
            ctl.tmrClear = 1'b1;
            phaseNxt     = P_STALL;
            stateNxt     = S_LOWGO;
          end else if (tmrExpired) begin
            ctl.selOff = 1'b1;
            ctl.wrOff  = 1'b1;
            abortNxt   = 1'b1;
            statNxt    = LD_BSY_TO;
            stateNxt   = S_IDLE;
          end else begin
            stateNxt = S_LOWGO;
          end
        end else begin
          phaseNxt = P_BYTE;
          stateNxt = bytesLeftZero ? S_DESEL : S_FETCH;
        end
      end
      S_DESEL: begin
        ctl.selOff = 1'b1;
        stateNxt   = S_WROFF;
      end
      S_WROFF: begin
        ctl.wrOff    = 1'b1;
        ctl.tmrClear = 1'b1;
        phaseNxt     = P_DONE;
        stateNxt     = S_DCHK;
      end
      S_DCHK: begin
        if (cfgDone) begin
          statNxt  = LD_OK;
          stateNxt = S_IDLE;
        end else if (tmrExpired) begin
          abortNxt = 1'b1;
          statNxt  = LD_DONE_TO;
          stateNxt = S_IDLE;
        end else begin
          stateNxt = S_LOWGO;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      phase      <= P_BYTE;
      stat       <= LD_IDLE;
      abortPulse <= 1'b0;
    end else begin
      state      <= stateNxt;
      phase      <= phaseNxt;
      stat       <= statNxt;
      abortPulse <= abortNxt;
    end
  end

  assign inReady = (state == S_FETCH);
  assign status  = stat;

  // R12
  run_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (stat == LD_RUN));

  // R11
  abort_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  // R11
  abort_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (stat == LD_RDY_TO || stat == LD_BSY_TO || stat == LD_DONE_TO));

  // R13
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE) |=> (state != S_PROG || $past(state) == S_PROG));

endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
  import cfg_par_loader_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PROG_CYC    = 100,
  parameter int HALF_CYC    = 2,
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteTotal,
  input  logic             stallEn,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             cfgInit,
  input  logic             cfgBusy,
  input  logic             cfgDone,
  output logic             devProg,
  output logic             devSel,
  output logic             devWrite,
  output logic             devClk,
  output logic [7:0]       devData,
  output logic             abortPulse,
  output logic [2:0]       status
);

  dp_ctl_t ctl;
  logic    dlyDone, tmrExpired, bytesLeftZero;

  cfg_par_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stallEn(stallEn),
    .inValid(inValid), .cfgInit(cfgInit), .cfgBusy(cfgBusy),
    .cfgDone(cfgDone), .dlyDone(dlyDone), .tmrExpired(tmrExpired),
    .bytesLeftZero(bytesLeftZero), .ctl(ctl), .inReady(inReady),
    .abortPulse(abortPulse), .status(status)
  );

  cfg_par_datapath #(
    .DATA_W(8), .CNT_W(CNT_W), .PROG_CYC(PROG_CYC),
    .HALF_CYC(HALF_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .byteTotal(byteTotal), .devProg(devProg), .devSel(devSel),
    .devWrite(devWrite), .devClk(devClk), .devData(devData),
    .dlyDone(dlyDone), .tmrExpired(tmrExpired),
    .bytesLeftZero(bytesLeftZero)
  );

  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (devSel && devWrite && devClk));

  // R3
  sel_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devSel) |-> (devWrite && devClk));

endmodule

// File: tb/cfg_par_loader_test.sv
`timescale 1ns/1ps
module cfg_par_loader_test;

  localparam int CW = 8;
  localparam int PC = 4;
  localparam int HC = 2;
  localparam int TO = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] byteTotal = '0;
  logic stallEn = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic cfgInit = 1'b0, cfgBusy = 1'b0, cfgDone = 1'b0;
  logic devProg, devSel, devWrite, devClk, abortPulse;
  logic [7:0] devData;
  logic [2:0] status;

  always #2.5 clk = ~clk;

  cfg_par_loader #(.CNT_W(CW), .PROG_CYC(PC), .HALF_CYC(HC), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rstN(rstN), .start(start), .byteTotal(byteTotal),
    .stallEn(stallEn), .inData(inData), .inValid(inValid), .inReady(inReady),
    .cfgInit(cfgInit), .cfgBusy(cfgBusy), .cfgDone(cfgDone),
    .devProg(devProg), .devSel(devSel), .devWrite(devWrite), .devClk(devClk),
    .devData(devData), .abortPulse(abortPulse), .status(status)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // device model settings
  int initDelay = 10;
  bit initHang = 1'b0;
  int busyAt = -1, busyLen = 0;
  int doneAfter = 3;

  // model observations
  logic [7:0] rxBuf [0:31];
  int rxCnt, selEdges, doneEdges, progRises, progWidth, lowRun, lowMin, lowMax;
  int cyc, selFallCyc, wrFallCyc, abortCnt, relCnt, busyLeft;
  bit armed, selRiseOk, selRiseSeen;
  logic prevProg = 1'b0, prevClk = 1'b1, prevSel = 1'b0, prevWr = 1'b0;

  // stream source
  logic [7:0] txBuf [0:31];
  int txLen = 0, txIdx = 0;
  bit streamOn = 1'b0, gapMode = 1'b0, gapTog = 1'b0, pendFire = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (abortPulse) abortCnt++;
    if (devProg) begin
      if (!prevProg) begin progRises++; progWidth = 0; end
      progWidth++;
      cfgInit = 1'b0; cfgDone = 1'b0; cfgBusy = 1'b0; relCnt = 0; armed = 1'b0;
    end else if (progRises > 0 && !cfgInit && !initHang) begin
      relCnt++;
      if (relCnt >= initDelay) cfgInit = 1'b1;
    end
    if (devSel && !prevSel && !selRiseSeen) begin
      selRiseSeen = 1'b1;
      selRiseOk = devWrite && devClk;
    end
    if (devClk && !prevClk) begin
      if (devSel && devWrite) begin
        selEdges++;
        if (!cfgBusy) begin
          if (rxCnt < 32) rxBuf[rxCnt] = devData;
          if (rxCnt == busyAt) begin cfgBusy = 1'b1; busyLeft = busyLen; end
          rxCnt++;
        end else begin
          busyLeft--;
          if (busyLeft <= 0) cfgBusy = 1'b0;
        end
      end else if (armed) doneEdges++;
    end
    if (!devClk) lowRun++;
    else if (lowRun > 0) begin
      if (lowRun < lowMin) lowMin = lowRun;
      if (lowRun > lowMax) lowMax = lowRun;
      lowRun = 0;
    end
    if (prevSel && !devSel) begin selFallCyc = cyc; armed = 1'b1; cfgBusy = 1'b0; end
    if (prevWr && !devWrite) wrFallCyc = cyc;
    if (armed && doneAfter >= 0 && doneEdges >= doneAfter) cfgDone = 1'b1;
    prevProg = devProg; prevClk = devClk; prevSel = devSel; prevWr = devWrite;
  end

  always @(negedge clk) begin
    if (pendFire) begin txIdx++; pendFire = 1'b0; end
    if (streamOn && txIdx < txLen) begin
      if (gapMode && gapTog) begin inValid = 1'b0; gapTog = 1'b0; end
      else begin inValid = 1'b1; inData = txBuf[txIdx]; gapTog = 1'b1; end
    end else inValid = 1'b0;
    pendFire = inValid && inReady;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    @(posedge clk);
    rxCnt = 0; selEdges = 0; doneEdges = 0; progRises = 0; progWidth = 0;
    lowRun = 0; lowMin = 1000; lowMax = 0; selFallCyc = 0; wrFallCyc = 0;
    abortCnt = 0; relCnt = 0; busyLeft = 0; armed = 1'b0;
    selRiseOk = 1'b0; selRiseSeen = 1'b0; txIdx = 0; pendFire = 1'b0; gapTog = 1'b0;
  endtask

  task automatic runLoad(input int n, input bit stall, input bit gaps, input bit midStart);
    clearModel();
    for (int i = 0; i < 32; i++) txBuf[i] = 8'(i * 37 + n * 11 + 5);
    txLen = n; gapMode = gaps; stallEn = stall; streamOn = 1'b1;
    @(negedge clk);
    byteTotal = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(status == 3'd1, "R12 running status", int'(status), 1);
    for (int w = 0; w < 20000 && status == 3'd1; w++) begin
      @(negedge clk);
      if (midStart && w == 30) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    streamOn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit bytesMatch(input int n);
    for (int i = 0; i < n; i++) if (rxBuf[i] !== txBuf[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic testReset();
    check(status == 3'd0, "R12 reset status idle", int'(status), 0);
    check(!devProg && !devSel && !devWrite, "R1 reset pins released",
          int'({devProg, devSel, devWrite}), 0);
    check(devClk == 1'b1 && !inReady && !abortPulse, "R3 reset clock parked high",
          int'({devClk, inReady, abortPulse}), 4);
  endtask

  task automatic testNormal();
    busyAt = -1; doneAfter = 3; initHang = 1'b0;
    runLoad(6, 1'b0, 1'b0, 1'b0);
    check(status == 3'd2, "R9 success status", int'(status), 2);
    check(rxCnt == 6 && bytesMatch(6), "R4 bytes in order", rxCnt, 6);
    check(selEdges == 6, "R4 one edge per byte", selEdges, 6);
    check(doneEdges == 3, "R9 post-load clocks", doneEdges, 3);
    check(progWidth == PC, "R1 program width", progWidth, PC);
    check(lowMin == HC && lowMax == HC, "R4 clock low width", lowMax, HC);
    check(wrFallCyc - selFallCyc == 1, "R6 write after select", wrFallCyc - selFallCyc, 1);
    check(selRiseOk, "R3 select with clock high", int'(selRiseOk), 1);
    check(abortCnt == 0, "R11 no abort on success", abortCnt, 0);
  endtask

  task automatic testStall();
    busyAt = 2; busyLen = 3; doneAfter = 2;
    runLoad(7, 1'b1, 1'b1, 1'b0);
    check(rxCnt == 7 && bytesMatch(7), "R5 bytes with valid gaps", rxCnt, 7);
    check(selEdges == 10, "R7 stall clocks issued", selEdges, 10);
    check(status == 3'd2, "R7 stall load success", int'(status), 2);
  endtask

  task automatic testNoStall();
    busyAt = 1; busyLen = 3; doneAfter = 2;
    runLoad(5, 1'b0, 1'b0, 1'b0);
    check(selEdges == 5, "R7 busy ignored when disabled", selEdges, 5);
    check(status == 3'd2, "R7 no-stall status", int'(status), 2);
  endtask

  task automatic testBusyTimeout();
    busyAt = 1; busyLen = 100000; doneAfter = 2;
    runLoad(4, 1'b1, 1'b0, 1'b0);
    check(status == 3'd4, "R8 busy timeout status", int'(status), 4);
    check(abortCnt == 1, "R11 single abort pulse", abortCnt, 1);
    check(!devSel && !devWrite, "R11 port released on abort", int'({devSel, devWrite}), 0);
  endtask

  task automatic testReadyTimeout();
    busyAt = -1; initHang = 1'b1; doneAfter = 2;
    runLoad(3, 1'b0, 1'b0, 1'b0);
    check(status == 3'd3, "R2 ready timeout status", int'(status), 3);
    check(selEdges == 0 && !selRiseSeen, "R2 select never asserted", selEdges, 0);
    check(abortCnt == 1, "R11 abort on ready timeout", abortCnt, 1);
    initHang = 1'b0;
  endtask

  task automatic testDoneTimeout();
    busyAt = -1; doneAfter = -1;
    runLoad(3, 1'b0, 1'b0, 1'b0);
    check(status == 3'd5, "R10 done timeout status", int'(status), 5);
    check(doneEdges > 10, "R10 clocks issued while waiting", doneEdges, 11);
    check(abortCnt == 1, "R11 abort on done timeout", abortCnt, 1);
  endtask

  task automatic testZero();
    busyAt = -1; doneAfter = 2;
    runLoad(0, 1'b0, 1'b0, 1'b0);
    check(status == 3'd2, "R14 zero-length status", int'(status), 2);
    check(selEdges == 0, "R14 no data clocks", selEdges, 0);
    check(doneEdges == 2, "R14 done clocks", doneEdges, 2);
  endtask

  task automatic testMidStart();
    busyAt = -1; doneAfter = 1;
    runLoad(6, 1'b0, 1'b0, 1'b1);
    check(progRises == 1, "R13 start ignored mid-load", progRises, 1);
    check(rxCnt == 6 && bytesMatch(6), "R13 load unaffected", rxCnt, 6);
    check(status == 3'd2, "R12 final status held", int'(status), 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testStall();
    testNoStall();
    testBusyTimeout();
    testReadyTimeout();
    testDoneTimeout();
    testZero();
    testMidStart();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule